// File: doc/BRIEF.md
# Clock-Recovery Lock Source and Link-Fault Controller

This block runs once per receive channel, clocked by the recovered clock. It decides whether the channel's clock-recovery loop should follow the incoming serial data or fall back to the local reference clock. It produces one select output for that choice. It also drives an active-low link-fault flag that summarises the health of the channel.

Three monitors decide whether the loop may follow the data:
- An external analog amplitude flag.
- A run-length monitor on the recovered bit stream. It counts identical bits on each bit strobe.
- A frequency range checker. It counts recovered-clock cycles across a fixed number of reference edges and compares the count against a rate band chosen by a three-level select, with hysteresis.

A watchdog detects a missing reference. A control input reduces the lock decision to the range check alone. A second control forces the loop onto the reference. After any loss of validity, the loop goes back to data tracking only after a run of clean evaluation windows.

Top module: `cdr_lock_ctrl`

## Requirements
- R1: While `rst` is high, and in the first sample after it falls, `lock_to_data` is 0 and `link_fault_n` is 0.
- R2: With `monitors_en` high, `lock_to_data` is 1 only while `amp_ok` is high, the range check is valid and the run-length monitor is not tripped. If any one of these fails, `lock_to_data` reaches 0 within two cycles.
- R3: With `monitors_en` low, only the range check (and `data_track_en`) governs `lock_to_data`. A low `amp_ok` or a long run of identical bits does not pull the loop off the data.
- R4: On each cycle with `rx_bit_stb` high, a bit equal to the previous strobed bit lengthens the current run, and a differing bit restarts the run at length 1. A run of 60 identical bits trips the low-density condition. A run of 55 identical bits does not.
- R5: When `data_track_en` is low, `lock_to_data` is 0 and `link_fault_n` is 0 from the next cycle, whatever the monitors report.
- R6: `link_fault_n` is a registered active-low OR of six conditions: range invalid, `amp_ok` low, low density, `chan_en` low, `data_track_en` low, and reference absent. A low `chan_en` raises the fault but leaves `lock_to_data` unchanged.
- R7: `rate_sel` 2'b00 selects 195–400 MBd, 2'b01 selects 400–800 MBd, 2'b10 selects 800–1500 MBd, and 2'b11 is read as 2'b01. The measurement counts `clk` cycles over 16 rising reference edges, so with a 25 MHz reference the bands are 124..256, 256..512 and 512..960 counts. The first window after reset or after a reference loss is discarded.
- R8: The range check uses a 4-count hysteresis. Once valid, it stays valid while the count lies within [lo-4, hi+4]. Once invalid, it becomes valid only when the count lies within [lo+4, hi-4].
- R9: When 256 `clk` cycles pass without a rising edge of the synchronised `ref_clk_in`, the reference is absent. The range check becomes invalid, `link_fault_n` goes 0 and `lock_to_data` goes 0.
- R10: After any loss of validity, `lock_to_data` returns to 1 only after 16 consecutive window closes during which all enabled checks stayed valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Recovered serial bit |
| rx_bit_stb | input | 1 | Marks a cycle carrying a new bit |
| amp_ok | input | 1 | Amplitude above threshold (from the analog detector) |
| ref_clk_in | input | 1 | Reference clock level (asynchronous) |
| rate_sel | input | 2 | Three-level rate band select |
| monitors_en | input | 1 | 1: all three monitors gate lock; 0: range only |
| data_track_en | input | 1 | 0 forces the loop onto the reference |
| chan_en | input | 1 | Channel enable |
| lock_to_data | output | 1 | 1: loop follows data; 0: loop follows reference |
| link_fault_n | output | 1 | Active-low link fault |

## Verification
Embedded properties check the following on every cycle:
- The forced-reference and fault responses to `data_track_en` and `chan_en`.
- The clearing of the run-length flag by a transition.
- The invalidation of the range check on reference loss.
- That `lock_to_data` only ever rises at a window close.

Only the bench scenarios can show the rest:
- The band limits and the hysteresis margins, which are exercised with reference patterns whose window sums land just inside and just outside each limit.
- The 16-window dwell before a return to data.
- The 60-bit run threshold.
- The range-only behaviour when the monitors are disabled.

// File: rtl/cdr_lc_pkg.sv
package cdr_lc_pkg;

    typedef enum logic [1:0] {
        BAND_LOW  = 2'b00,
        BAND_MID  = 2'b01,
        BAND_HIGH = 2'b10
    } rate_band_e;

    typedef struct packed {
        int lo;
        int hi;
    } band_lim_t;

    typedef struct packed {
        logic amp_good;
        logic range_good;
        logic dens_good;
        logic ref_good;
    } mon_status_t;

    localparam int LOW_MIN_MBD  = 195;
    localparam int LOW_MAX_MBD  = 400;
    localparam int MID_MIN_MBD  = 400;
    localparam int MID_MAX_MBD  = 800;
    localparam int HIGH_MIN_MBD = 800;
    localparam int HIGH_MAX_MBD = 1500;

    // The unused code reads as the middle band, like a floating ternary pin.
    function automatic rate_band_e decode_band(input logic [1:0] code);
        case (code)
            2'b00:   return BAND_LOW;
            2'b10:   return BAND_HIGH;
            default: return BAND_MID;
        endcase
    endfunction

    function automatic band_lim_t band_counts(input rate_band_e band,
                                              input int win_edges,
                                              input int ref_mhz);
        band_lim_t r;
        case (band)
            BAND_LOW: begin
                r.lo = (LOW_MIN_MBD * win_edges) / ref_mhz;
                r.hi = (LOW_MAX_MBD * win_edges) / ref_mhz;
            end
            BAND_HIGH: begin
                r.lo = (HIGH_MIN_MBD * win_edges) / ref_mhz;
                r.hi = (HIGH_MAX_MBD * win_edges) / ref_mhz;
            end
            default: begin
                r.lo = (MID_MIN_MBD * win_edges) / ref_mhz;
                r.hi = (MID_MAX_MBD * win_edges) / ref_mhz;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cdr_ref_watch.sv
module cdr_ref_watch #(
    parameter int REF_TIMEOUT = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_clk_in,
    output logic ref_edge,
    output logic ref_absent
);
    localparam int TMO_W = $clog2(REF_TIMEOUT + 1);

    logic [1:0]       sync_q;
    logic             last_q;
    logic [TMO_W-1:0] idle_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], ref_clk_in};
            last_q <= sync_q[1];
        end
    end

    assign ref_edge = sync_q[1] & ~last_q;

    always_ff @(posedge clk) begin
        if (rst || ref_edge)
            idle_cnt <= '0;
        else if (idle_cnt != TMO_W'(REF_TIMEOUT))
            idle_cnt <= idle_cnt + TMO_W'(1);
    end

    assign ref_absent = (idle_cnt == TMO_W'(REF_TIMEOUT));

    // R9
    edge_clears_absent_chk: assert property (@(posedge clk) disable iff (rst)
        ref_edge |=> !ref_absent);

endmodule

// File: rtl/cdr_density_mon.sv
module cdr_density_mon #(
    parameter int RUN_LIMIT = 60
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_bit,
    input  logic rx_bit_stb,
    output logic low_density
);
    localparam int RUN_W = $clog2(RUN_LIMIT + 1);

    logic             prev_bit;
    logic [RUN_W-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_bit <= 1'b0;
            run_len  <= '0;
        end else if (rx_bit_stb) begin
            prev_bit <= rx_bit;
            if (rx_bit != prev_bit)
                run_len <= RUN_W'(1);
            else if (run_len != RUN_W'(RUN_LIMIT))
                run_len <= run_len + RUN_W'(1);
        end
    end

    assign low_density = (run_len == RUN_W'(RUN_LIMIT));

    // R4
    transition_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_bit_stb && (rx_bit != prev_bit)) |=> !low_density);

    // R4
    idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_bit_stb |=> $stable(low_density));

endmodule

// File: rtl/cdr_range_mon.sv
module cdr_range_mon
    import cdr_lc_pkg::*;
#(
    parameter int WIN_EDGES = 16,
    parameter int REF_MHZ   = 25,
    parameter int HYST      = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_edge,
    input  logic       ref_absent,
    input  logic [1:0] rate_sel,
    output logic       win_done,
    output logic       range_ok
);
    localparam int MAX_CNT = (HIGH_MAX_MBD * WIN_EDGES) / REF_MHZ + HYST;
    localparam int CNT_W   = $clog2(MAX_CNT + 2) + 1;
    localparam int EDGE_W  = $clog2(WIN_EDGES + 1);

    logic [CNT_W-1:0]  cyc_cnt;
    logic [EDGE_W-1:0] edge_cnt;
    logic              primed;
    logic              range_ok_q;
    logic              close;
    logic              fits;
    band_lim_t         lim;
    int                meas;

    assign close = ref_edge && (edge_cnt == EDGE_W'(WIN_EDGES - 1));

    always_comb begin
        lim  = band_counts(decode_band(rate_sel), WIN_EDGES, REF_MHZ);
        meas = int'(cyc_cnt) + 1;
        if (range_ok_q)
            fits = (meas >= lim.lo - HYST) && (meas <= lim.hi + HYST);
        else
            fits = (meas >= lim.lo + HYST) && (meas <= lim.hi - HYST);
    end

    always_ff @(posedge clk) begin
        if (rst || ref_absent) begin
            cyc_cnt    <= '0;
            edge_cnt   <= '0;
            primed     <= 1'b0;
            range_ok_q <= 1'b0;
        end else if (close) begin
            cyc_cnt  <= '0;
            edge_cnt <= '0;
            primed   <= 1'b1;
            if (primed)
                range_ok_q <= fits;
        end else begin
            if (ref_edge)
                edge_cnt <= edge_cnt + EDGE_W'(1);
            if (cyc_cnt != {CNT_W{1'b1}})
                cyc_cnt <= cyc_cnt + CNT_W'(1);
        end
    end

    assign win_done = close && primed;
    assign range_ok = range_ok_q;

    // R9
    absent_kills_range_chk: assert property (@(posedge clk) disable iff (rst)
        ref_absent |=> !range_ok);

    // R7
    range_moves_at_close_chk: assert property (@(posedge clk) disable iff (rst)
        (!ref_absent && !win_done) |=> $stable(range_ok));

endmodule

// File: rtl/cdr_lock_fsm.sv
module cdr_lock_fsm
    import cdr_lc_pkg::*;
#(
    parameter int STABLE_WINS = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        win_done,
    input  logic        monitors_en,
    input  logic        data_track_en,
    input  mon_status_t status,
    output logic        lock_to_data
);
    localparam int STAB_W = $clog2(STABLE_WINS + 1);

    logic [STAB_W-1:0] stab_cnt;
    logic              bad_seen;
    logic              lock_q;
    logic              checks_ok;

    always_comb begin
        if (monitors_en)
            checks_ok = status.amp_good & status.range_good & status.dens_good;
        else
            checks_ok = status.range_good;
        checks_ok = checks_ok & data_track_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stab_cnt <= '0;
            bad_seen <= 1'b0;
            lock_q   <= 1'b0;
        end else if (!checks_ok) begin
            stab_cnt <= '0;
            bad_seen <= 1'b1;
            lock_q   <= 1'b0;
        end else if (win_done) begin
            bad_seen <= 1'b0;
            if (bad_seen) begin
                stab_cnt <= '0;
            end else if (stab_cnt != STAB_W'(STABLE_WINS)) begin
                stab_cnt <= stab_cnt + STAB_W'(1);
                if (stab_cnt == STAB_W'(STABLE_WINS - 1))
                    lock_q <= 1'b1;
            end
        end
    end

    assign lock_to_data = lock_q;

    // R5
    forced_ref_chk: assert property (@(posedge clk) disable iff (rst)
        !data_track_en |=> !lock_to_data);

    // R3
    range_only_chk: assert property (@(posedge clk) disable iff (rst)
        (!monitors_en && !status.range_good) |=> !lock_to_data);

    // R2
    all_monitors_chk: assert property (@(posedge clk) disable iff (rst)
        (monitors_en && !(status.amp_good && status.dens_good)) |=> !lock_to_data);

    // R10
    rise_at_close_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_to_data) |-> $past(win_done));

endmodule

// File: rtl/cdr_lock_ctrl.sv
module cdr_lock_ctrl
    import cdr_lc_pkg::*;
#(
    parameter int WIN_EDGES   = 16,
    parameter int REF_MHZ     = 25,
    parameter int HYST        = 4,
    parameter int RUN_LIMIT   = 60,
    parameter int REF_TIMEOUT = 256,
    parameter int STABLE_WINS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_bit,
    input  logic       rx_bit_stb,
    input  logic       amp_ok,
    input  logic       ref_clk_in,
    input  logic [1:0] rate_sel,
    input  logic       monitors_en,
    input  logic       data_track_en,
    input  logic       chan_en,
    output logic       lock_to_data,
    output logic       link_fault_n
);
    logic        ref_edge;
    logic        ref_absent;
    logic        low_density;
    logic        win_done;
    logic        range_ok;
    logic        fault_n_q;
    mon_status_t status;

    cdr_ref_watch #(.REF_TIMEOUT(REF_TIMEOUT)) u_watch (
        .clk        (clk),
        .rst        (rst),
        .ref_clk_in (ref_clk_in),
        .ref_edge   (ref_edge),
        .ref_absent (ref_absent)
    );

    cdr_density_mon #(.RUN_LIMIT(RUN_LIMIT)) u_dens (
        .clk         (clk),
        .rst         (rst),
        .rx_bit      (rx_bit),
        .rx_bit_stb  (rx_bit_stb),
        .low_density (low_density)
    );

    cdr_range_mon #(
        .WIN_EDGES (WIN_EDGES),
        .REF_MHZ   (REF_MHZ),
        .HYST      (HYST)
    ) u_range (
        .clk        (clk),
        .rst        (rst),
        .ref_edge   (ref_edge),
        .ref_absent (ref_absent),
        .rate_sel   (rate_sel),
        .win_done   (win_done),
        .range_ok   (range_ok)
    );

    always_comb begin
        status.amp_good   = amp_ok;
        status.range_good = range_ok;
        status.dens_good  = ~low_density;
        status.ref_good   = ~ref_absent;
    end

    cdr_lock_fsm #(.STABLE_WINS(STABLE_WINS)) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .win_done      (win_done),
        .monitors_en   (monitors_en),
        .data_track_en (data_track_en),
        .status        (status),
        .lock_to_data  (lock_to_data)
    );

    always_ff @(posedge clk) begin
        if (rst)
            fault_n_q <= 1'b0;
        else
            fault_n_q <= status.range_good & status.amp_good & status.dens_good
                       & status.ref_good & chan_en & data_track_en;
    end

    assign link_fault_n = fault_n_q;

    // R6
    chan_off_fault_chk: assert property (@(posedge clk) disable iff (rst)
        !chan_en |=> !link_fault_n);

    // R5
    local_fault_chk: assert property (@(posedge clk) disable iff (rst)
        !data_track_en |=> !link_fault_n);

    // R9
    absent_fault_chk: assert property (@(posedge clk) disable iff (rst)
        ref_absent |=> !link_fault_n);

endmodule

// File: tb/cdr_lock_ctrl_test.sv
module cdr_lock_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 13;
    localparam int WIN = 16;

    // Range table: rate_sel, reference period, extra cycles once per 16 edges,
    // expected link_fault_n given the state left by the previous entry.
    localparam logic [1:0] V_SEL [NVEC] = '{2'b00, 2'b00, 2'b00, 2'b00, 2'b00,
                                            2'b01, 2'b01, 2'b01, 2'b01,
                                            2'b10, 2'b11, 2'b00, 2'b00};
    localparam int V_N [NVEC] = '{10, 7, 7, 7, 8, 20, 33, 32, 31, 40, 40, 5, 10};
    localparam int V_X [NVEC] = '{0, 10, 7, 14, 0, 0, 0, 2, 0, 0, 0, 0, 0};
    localparam logic V_OK [NVEC] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0,
                                     1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_bit = 1'b0;
    logic       rx_bit_stb = 1'b1;
    logic       amp_ok = 1'b1;
    logic       ref_clk_in = 1'b0;
    logic [1:0] rate_sel = 2'b00;
    logic       monitors_en = 1'b1;
    logic       data_track_en = 1'b1;
    logic       chan_en = 1'b1;
    logic       lock_to_data;
    logic       link_fault_n;

    int  checks = 0;
    int  failures = 0;
    int  gen_n = 10;
    int  gen_x = 0;
    logic ref_on = 1'b1;
    logic hold_bits = 1'b0;

    cdr_lock_ctrl uut (
        .clk           (clk),
        .rst           (rst),
        .rx_bit        (rx_bit),
        .rx_bit_stb    (rx_bit_stb),
        .amp_ok        (amp_ok),
        .ref_clk_in    (ref_clk_in),
        .rate_sel      (rate_sel),
        .monitors_en   (monitors_en),
        .data_track_en (data_track_en),
        .chan_en       (chan_en),
        .lock_to_data  (lock_to_data),
        .link_fault_n  (link_fault_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    initial begin
        forever begin
            for (int i = 0; i < WIN; i++) begin
                int p;
                p = gen_n + ((i == WIN - 1) ? gen_x : 0);
                @(negedge clk);
                ref_clk_in = ref_on;
                for (int k = 1; k < p; k++) begin
                    @(negedge clk);
                    ref_clk_in = 1'b0;
                end
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (!hold_bits) rx_bit = ~rx_bit;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        wait_cyc(5);
        check("R1 lock in reset", lock_to_data, 1'b0);
        check("R1 fault in reset", link_fault_n, 1'b0);
        rst = 1'b0;
        wait_cyc(1);
        check("R1 lock after reset", lock_to_data, 1'b0);
        check("R1 fault after reset", link_fault_n, 1'b0);

        // 160-cycle windows: range valid after two closes, lock after 16 more.
        wait_cyc(12 * 160);
        check("R10 no lock before dwell", lock_to_data, 1'b0);
        check("R7 low band 160 counts valid", link_fault_n, 1'b1);
        wait_cyc(10 * 160);
        check("R2 lock with all monitors valid", lock_to_data, 1'b1);

        amp_ok = 1'b0;
        wait_cyc(3);
        check("R2 amplitude loss drops lock", lock_to_data, 1'b0);
        check("R6 amplitude loss faults", link_fault_n, 1'b0);
        amp_ok = 1'b1;
        wait_cyc(10 * 160);
        check("R10 still on reference mid dwell", lock_to_data, 1'b0);
        wait_cyc(10 * 160);
        check("R10 relock after dwell", lock_to_data, 1'b1);

        hold_bits = 1'b1;
        wait_cyc(52);
        check("R4 run of 55 not tripped", link_fault_n, 1'b1);
        wait_cyc(18);
        check("R4 run of 60 trips fault", link_fault_n, 1'b0);
        check("R2 low density drops lock", lock_to_data, 1'b0);

        monitors_en = 1'b0;
        wait_cyc(20 * 160);
        check("R3 range-only lock despite low density", lock_to_data, 1'b1);
        check("R6 density fault stays", link_fault_n, 1'b0);
        amp_ok = 1'b0;
        wait_cyc(100);
        check("R3 amplitude ignored for lock", lock_to_data, 1'b1);
        amp_ok = 1'b1;
        hold_bits = 1'b0;
        monitors_en = 1'b1;
        wait_cyc(20 * 160);
        check("R2 lock restored", lock_to_data, 1'b1);
        check("R6 no fault when all good", link_fault_n, 1'b1);

        chan_en = 1'b0;
        wait_cyc(3);
        check("R6 channel off faults", link_fault_n, 1'b0);
        check("R6 channel off keeps lock", lock_to_data, 1'b1);
        chan_en = 1'b1;
        wait_cyc(3);
        check("R6 channel on clears fault", link_fault_n, 1'b1);

        data_track_en = 1'b0;
        wait_cyc(3);
        check("R5 forced reference", lock_to_data, 1'b0);
        check("R5 forced reference faults", link_fault_n, 1'b0);
        data_track_en = 1'b1;
        wait_cyc(3);

        for (int v = 0; v < NVEC; v++) begin
            rate_sel = V_SEL[v];
            gen_n = V_N[v];
            gen_x = V_X[v];
            wait_cyc(3400);
            check((v == 1 || v == 3 || v == 7) ? "R8 hysteresis hold" : "R7 band check",
                  link_fault_n, V_OK[v]);
        end

        wait_cyc(20 * 160);
        check("R10 lock before reference loss", lock_to_data, 1'b1);
        ref_on = 1'b0;
        wait_cyc(120);
        check("R9 reference not yet absent", link_fault_n, 1'b1);
        wait_cyc(180);
        check("R9 reference absent faults", link_fault_n, 1'b0);
        check("R9 reference absent drops lock", lock_to_data, 1'b0);
        ref_on = 1'b1;
        wait_cyc(4 * 160);
        check("R9 recovery after reference returns", link_fault_n, 1'b1);

        finish_run();
    end
endmodule